// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Expander

This block turns a serial bit stream into a parallel output word in two steps. A shift stage takes one bit per rising edge of its own shift clock. A separate holding stage copies the whole shift word when its own storage clock rises. New data can therefore be shifted in while the parallel outputs keep showing the previous word. They change in one step when the word is latched.

An active-low clear empties the shift stage at once, whatever the shift clock is doing. It leaves the holding stage alone. An active-low output enable turns off the parallel outputs. Tri-state behaviour is modelled as a data vector plus a per-bit drive-enable vector. The last shift stage is brought out as a cascade output so that several expanders can be chained. This output is always driven. When both clocks come from one signal, the holding stage always shows the shift word from before that edge.

Top module: `serial_latch_expander`

## Requirements
- R1: On each rising `shift_clk` edge, shift stage bit 0 takes `ser_in` and each bit i (i ≥ 1) takes bit i-1. Shifting the bits of a word most-significant first leaves that word in the shift stage after WIDTH edges.
- R2: Only rising clock edges change state. Changing `ser_in` while `shift_clk` is high and then lowering the clock has no effect on the shift stage.
- R3: On a rising `store_clk` edge, the holding stage copies the shift stage. Between storage edges, `par_q` does not follow shifting.
- R4: `clr_n` low empties the shift stage at once and holds it empty even across rising `shift_clk` edges. The first edge after release shifts exactly one bit into an empty stage.
- R5: `clr_n` never changes the holding stage.
- R6: With `oe_n` high, every bit of `par_drv` is 0 and every bit of `par_q` is 0. With `oe_n` low, every bit of `par_drv` is 1 and `par_q` equals the holding stage.
- R7: `cascade_out` equals shift stage bit WIDTH-1, whatever the value of `oe_n`.
- R8: When both clocks are one signal, each edge latches the shift word as it was before that edge, so the holding stage lags by one edge.
- R9: With `STORE_POR` = 1, `por_n` low sets the holding stage to zero. A WIDTH below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift stage clock, rising edge |
| store_clk | input | 1 | Holding stage clock, rising edge |
| por_n | input | 1 | Active-low power-on reset of the holding stage (used when STORE_POR=1) |
| clr_n | input | 1 | Active-low asynchronous clear of the shift stage only |
| ser_in | input | 1 | Serial data bit |
| oe_n | input | 1 | Active-low parallel output enable |
| par_q | output | WIDTH | Parallel data, zero while disabled |
| par_drv | output | WIDTH | Per-bit drive enable of `par_q` |
| cascade_out | output | 1 | Last shift stage bit, for chaining |

## Verification
The bench shifts and latches all 256 byte values. A reversed shift direction or a swapped bit order would show up as a wrong word on `par_q`. It holds the clear low across a shift edge and then latches. A clear that reached the holding stage, or that let the clock through, would show a nonzero or changed word. After release, a partial shift would leave more than one bit set. With one shared clock, a design without the one-edge lag would show the new word too early. With the outputs disabled, the bench keeps shifting and watches `cascade_out`. A design that gated the cascade with the enable would stop following the shift stage.

// File: rtl/sle_pkg.sv
package sle_pkg;
   localparam int SLE_MIN_WIDTH = 2;

   function automatic logic drive_on(input logic enable_n);
      return ~enable_n;
   endfunction
endpackage

// File: rtl/sle_shift_stage.sv
module sle_shift_stage #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             din,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q <= '0;
      else        q <= {q[WIDTH-2:0], din};
   end
endmodule

// File: rtl/sle_hold_stage.sv
module sle_hold_stage #(
   parameter int WIDTH     = 8,
   parameter bit STORE_POR = 1'b1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STORE_POR) begin : g_por
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_nopor
         logic unused_por;
         assign unused_por = por_n;
         always_ff @(posedge clk) q <= d;
      end
   endgenerate
endmodule

// File: rtl/sle_out_gate.sv
module sle_out_gate #(
   parameter int WIDTH = 8
) (
   input  logic             enable_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] drv
);
   import sle_pkg::*;
   logic on;
   assign on = drive_on(enable_n);

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         assign drv[b] = on;
         assign q[b]   = on & d[b];
      end
   endgenerate
endmodule

// File: rtl/serial_latch_expander.sv
module serial_latch_expander #(
   parameter int WIDTH     = 8,
   parameter bit STORE_POR = 1'b1
) (
   input  logic             shift_clk,
   input  logic             store_clk,
   input  logic             por_n,
   input  logic             clr_n,
   input  logic             ser_in,
   input  logic             oe_n,
   output logic [WIDTH-1:0] par_q,
   output logic [WIDTH-1:0] par_drv,
   output logic             cascade_out
);
   import sle_pkg::*;
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < SLE_MIN_WIDTH) begin : g_bad_width
         $error("serial_latch_expander: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] shift_q;
   logic [WIDTH-1:0] hold_q;

   sle_shift_stage #(.WIDTH(WIDTH)) i_shift (
      .clk   (shift_clk),
      .clr_n (clr_n),
      .din   (ser_in),
      .q     (shift_q)
   );

   sle_hold_stage #(.WIDTH(WIDTH), .STORE_POR(STORE_POR)) i_hold (
      .clk   (store_clk),
      .por_n (por_n),
      .d     (shift_q),
      .q     (hold_q)
   );

   sle_out_gate #(.WIDTH(WIDTH)) i_gate (
      .enable_n (oe_n),
      .d        (hold_q),
      .q        (par_q),
      .drv      (par_drv)
   );

   assign cascade_out = shift_q[MSB];
endmodule

// File: rtl/sle_checker.sv
module sle_checker #(
   parameter int WIDTH = 8
) (
   input logic             shift_clk,
   input logic             store_clk,
   input logic             por_n,
   input logic             clr_n,
   input logic             ser_in,
   input logic             oe_n,
   input logic [WIDTH-1:0] shift_q,
   input logic [WIDTH-1:0] hold_q,
   input logic [WIDTH-1:0] par_q,
   input logic [WIDTH-1:0] par_drv,
   input logic             cascade_out
);
   AST_SHIFT_ADVANCE: assert property (@(posedge shift_clk) disable iff (!clr_n || !por_n)
      1'b1 |=> (shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0])) && (shift_q[0] == $past(ser_in))); // R1

   AST_CLEAR_EMPTIES: assert property (@(posedge shift_clk) disable iff (!por_n)
      !clr_n |-> shift_q == '0); // R4

   AST_STORE_COPY: assert property (@(posedge store_clk) disable iff (!por_n)
      1'b1 |=> hold_q == $past(shift_q)); // R3

   AST_OUTPUT_OFF: assert property (@(posedge store_clk) disable iff (!por_n)
      oe_n |-> (par_drv == '0) && (par_q == '0)); // R6

   AST_CASCADE_LAST: assert property (@(posedge shift_clk) disable iff (!clr_n || !por_n)
      1'b1 |=> cascade_out == $past(shift_q[WIDTH-2])); // R7
endmodule

bind serial_latch_expander sle_checker #(.WIDTH(WIDTH)) i_sle_checker (
   .shift_clk   (shift_clk),
   .store_clk   (store_clk),
   .por_n       (por_n),
   .clr_n       (clr_n),
   .ser_in      (ser_in),
   .oe_n        (oe_n),
   .shift_q     (shift_q),
   .hold_q      (hold_q),
   .par_q       (par_q),
   .par_drv     (par_drv),
   .cascade_out (cascade_out)
);

// File: tb/test_serial_latch_expander.sv
`timescale 1ns/1ps
module test_serial_latch_expander;
   localparam int W = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic shift_clk = 1'b0, store_clk = 1'b0;
   logic por_n = 1'b0, clr_n = 1'b0, ser_in = 1'b0, oe_n = 1'b0;
   logic [W-1:0] par_q, par_drv;
   logic cascade_out;
   logic shared = 1'b0;

   int errors = 0;
   int checks = 0;
   logic [W-1:0] exp_sr = '0;
   logic [W-1:0] exp_st = '0;

   serial_latch_expander #(.WIDTH(W), .STORE_POR(1'b1)) i_serial_latch_expander (
      .shift_clk(shift_clk), .store_clk(store_clk), .por_n(por_n), .clr_n(clr_n),
      .ser_in(ser_in), .oe_n(oe_n), .par_q(par_q), .par_drv(par_drv),
      .cascade_out(cascade_out));

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic shift_bit(input logic b);
      #1 ser_in = b;
      #1 shift_clk = 1'b1; if (shared) store_clk = 1'b1;
      if (clr_n) begin
         if (shared) exp_st = exp_sr;
         exp_sr = {exp_sr[W-2:0], b};
      end else if (shared) exp_st = '0;
      #2 shift_clk = 1'b0; store_clk = 1'b0;
   endtask

   task automatic latch();
      #1 store_clk = 1'b1;
      exp_st = exp_sr;
      #2 store_clk = 1'b0;
      #1;
   endtask

   initial begin
      #5 por_n = 1'b1;
      #3 clr_n = 1'b1;
      #2;
      chk("R9 reset hold", par_q, '0);
      chk("R6 drive on", par_drv, '1);
      chk("R7 reset cascade", {7'd0, cascade_out}, '0);

      // R1/R3 sweep of every byte
      for (int p = 0; p < 256; p++) begin
         for (int i = W-1; i >= 0; i--) shift_bit(p[i]);
         chk("R7 cascade msb", {7'd0, cascade_out}, {7'd0, p[7]});
         latch();
         chk("R1 sweep word", par_q, p[7:0]);
      end

      // R3: shifting does not disturb the latched word
      for (int i = 0; i < 3; i++) shift_bit(1'b1);
      chk("R3 hold between stores", par_q, 8'hFF);
      for (int i = 0; i < 8; i++) shift_bit(i[0]);
      chk("R3 hold before store", par_q, 8'hFF);
      latch();
      chk("R3 after store", par_q, 8'h55);

      // R2: rising edge captures, falling edge ignored
      #1 ser_in = 1'b1;
      #1 shift_clk = 1'b1; exp_sr = {exp_sr[6:0], 1'b1};
      #1 ser_in = 1'b0;
      #1 shift_clk = 1'b0;
      #2 ser_in = 1'b1;
      #2 ser_in = 1'b0;
      latch();
      chk("R2 falling edge no effect", par_q, 8'hAB);

      // R4/R5: clear during shifting
      for (int i = 0; i < 4; i++) shift_bit(1'b1);
      #1 clr_n = 1'b0; exp_sr = '0;
      #1;
      chk("R4 clear empties cascade", {7'd0, cascade_out}, '0);
      chk("R5 clear keeps hold", par_q, 8'hAB);
      shift_bit(1'b1);
      shift_bit(1'b1);
      chk("R5 hold after clocked clear", par_q, 8'hAB);
      latch();
      chk("R4 clear overrides clock", par_q, 8'h00);
      #1 clr_n = 1'b1;
      shift_bit(1'b1);
      latch();
      chk("R4 single bit after release", par_q, 8'h01);

      // R6/R7: output enable
      for (int i = 0; i < 7; i++) shift_bit(1'b0);
      latch();
      #1 oe_n = 1'b1;
      #1;
      chk("R6 disabled drive", par_drv, '0);
      chk("R6 disabled data", par_q, '0);
      chk("R7 cascade while disabled", {7'd0, cascade_out}, 8'd1);
      shift_bit(1'b0);
      #1;
      chk("R7 cascade follows shift disabled", {7'd0, cascade_out}, 8'd0);
      #1 oe_n = 1'b0;
      #1;
      chk("R6 re-enabled data", par_q, 8'h80);
      chk("R6 re-enabled drive", par_drv, '1);

      // R8: shared clock with one-edge lag
      #1 clr_n = 1'b0; exp_sr = '0;
      #1 clr_n = 1'b1;
      shared = 1'b1;
      for (int i = 0; i < 10; i++) begin
         shift_bit(i[0] ^ i[1]);
         #1;
         chk("R8 shared clock lag", par_q, exp_st);
      end
      shared = 1'b0;

      // R9: power-on reset clears holding stage
      #1 por_n = 1'b0;
      #1;
      chk("R9 por clears hold", par_q, '0);
      #1 por_n = 1'b1;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule